// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This unit turns a logical address (a segment register number plus an offset) into a linear address. Software loads 16-bit selectors into a small bank of segment registers. A translation request names one of those registers, gives an offset and a mode flag. The selector supplies an entry index, a table choice and a requested privilege level. The unit forms the entry address from the chosen table base and fetches the 8-byte descriptor as two 32-bit words over a valid/ready read port.

The base and limit pulled out of the descriptor are kept in a hidden copy that belongs to each segment register, so later requests through the same register need no memory traffic. In legacy mode the offset is checked against the limit and the base is added. In 64-bit mode the base counts as zero and the limit is not checked. Each accepted request ends in exactly one single-cycle result: either a linear address or a general-protection fault. The privilege level of the code-segment register is always visible on a separate output.

Top module: `seg_xlate_unit`

## Requirements
- R1: Selector bits [15:3] are the entry index, bit [2] picks the table (0 selects `gdt_base`, 1 selects `ldt_base`) and bits [1:0] are the requested privilege level.
- R2: On a miss, in either mode, the descriptor sits at table base + 8 × index. It is read as two 32-bit reads: the low word at that address, then the high word at address + 4. A read completes on a rising edge where `mem_rd_valid` and `mem_rd_ready` are both high, and the address is held stable until then.
- R3: Descriptor layout: low word [15:0] = limit[15:0], low word [31:16] = base[15:0], high word [7:0] = base[23:16], high word [19:16] = limit[19:16], high word [31:24] = base[31:24]. High word bits [15:8] and [23:20] are attribute bits that do not affect translation.
- R4: In legacy mode (`req_mode64`=0), an offset (compared at full width) greater than the 20-bit limit gives `gp_fault`. Otherwise `lin_addr` = (base + offset[31:0]) mod 2^32, zero-extended.
- R5: In 64-bit mode (`req_mode64`=1) no fault is raised and `lin_addr` equals the offset.
- R6: When the named segment register holds a valid hidden copy, no read is issued, and the result appears in the cycle after the accepting edge. It uses the stored copy even if the table bases have since changed.
- R7: Any write to a segment register invalidates its hidden copy, even when the value written is unchanged. The next request through that register fetches again.
- R8: A request is accepted when `req_valid` is high and `busy` is low. After a miss is accepted, `busy` is high from the next cycle until the cycle in which the result appears, where it is low. Reads are issued only while `busy` is high.
- R9: Each accepted request gives exactly one single-cycle pulse of either `lin_valid` or `gp_fault`, never both.
- R10: `cpl` equals bits [1:0] of the selector in segment register 0 (the code segment), updated in the cycle after the write.
- R11: After reset `busy`, `lin_valid`, `gp_fault`, `mem_rd_valid` and `cpl` are 0, and every hidden copy is invalid, so the first request through any register fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr_en | input | 1 | Load a selector into a segment register |
| sel_wr_idx | input | IDX_W | Segment register number to load (0 = code segment) |
| sel_wr_val | input | 16 | Selector value |
| gdt_base | input | MADDR_W | Global table base address |
| ldt_base | input | MADDR_W | Local table base address |
| req_valid | input | 1 | Translation request |
| req_seg | input | IDX_W | Segment register used by the request |
| req_off | input | OFF_W | Offset into the segment |
| req_mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| busy | output | 1 | Descriptor fetch in progress |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | MADDR_W | Read byte address |
| mem_rd_ready | input | 1 | Read completes; data valid this cycle |
| mem_rd_data | input | 32 | Read data |
| lin_valid | output | 1 | Linear address valid pulse |
| lin_addr | output | OFF_W | Linear address |
| gp_fault | output | 1 | General-protection fault pulse |
| cpl | output | 2 | Current privilege level |

## Verification
A hit must show its result at the first falling edge after the accepting edge. A miss shows its result at the falling edge after the rising edge that completes the second read, and `busy` must already be high at the first falling edge. The bench drives and samples only on falling edges. It counts falling edges from acceptance up to the result and checks that the count is exactly one for hits. It also counts completed reads per request, and checks the following falling edge to confirm the result was a single pulse. `cpl` is checked at the falling edge right after the selector write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int SEL_W  = 16;
  localparam int WORD_W = 32;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 20;

  // Only the translation-relevant part of a descriptor is kept.
  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [LIM_W-1:0]  limit;
  } seg_shadow_t;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_LO   = 2'd1,
    FS_HI   = 2'd2
  } fetch_state_e;
endpackage

// File: rtl/seg_hidden_cache.sv
module seg_hidden_cache
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              fill_en,
  input  logic [IDX_W-1:0]  fill_idx,
  input  seg_shadow_t       fill_shadow,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_valid,
  output seg_shadow_t       rd_shadow,
  output logic [1:0]        cs_rpl
);
  logic [NUM_SEGS-1:0][SEL_W-1:0] sel_all;
  logic [NUM_SEGS-1:0]            vld_all;
  seg_shadow_t [NUM_SEGS-1:0]     shd_all;

  for (genvar g = 0; g < NUM_SEGS; g++) begin : g_entry
    logic [SEL_W-1:0] sel_q, sel_d;
    logic             vld_q, vld_d;
    seg_shadow_t      shd_q, shd_d;
    logic             wr_hit, fill_hit;

    assign wr_hit   = wr_en && (wr_idx == IDX_W'(g));
    assign fill_hit = fill_en && (fill_idx == IDX_W'(g));

    always_comb begin
      sel_d = sel_q;
      vld_d = vld_q;
      shd_d = shd_q;
      if (fill_hit) begin
        vld_d = 1'b1;
        shd_d = fill_shadow;
      end
      if (wr_hit) begin
        sel_d = wr_sel;
        vld_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_q <= '0;
        vld_q <= 1'b0;
        shd_q <= '0;
      end else begin
        if (wr_hit) sel_q <= sel_d;
        if (wr_hit || fill_hit) begin
          vld_q <= vld_d;
          shd_q <= shd_d;
        end
      end
    end

    assign sel_all[g] = sel_q;
    assign vld_all[g] = vld_q;
    assign shd_all[g] = shd_q;
  end

  always_comb begin
    rd_sel    = '0;
    rd_valid  = 1'b0;
    rd_shadow = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_sel    = sel_all[i];
        rd_valid  = vld_all[i];
        rd_shadow = shd_all[i];
      end
    end
  end

  assign cs_rpl = sel_all[0][1:0];
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_xlate_pkg::*;
#(
  parameter int MADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MADDR_W-1:0] start_addr,
  output logic               mem_rd_valid,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_ready,
  input  logic [WORD_W-1:0]  mem_rd_data,
  output logic               busy,
  output logic               done,
  output seg_shadow_t        done_shadow
);
  fetch_state_e        state_q, state_d;
  logic [MADDR_W-1:0]  addr_q, addr_d;
  logic [WORD_W-1:0]   lo_q, lo_d;
  logic [11:0]         attr_unused;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    lo_d    = lo_q;
    unique case (state_q)
      FS_IDLE: if (start) begin
        state_d = FS_LO;
        addr_d  = start_addr;
      end
      FS_LO: if (mem_rd_ready) begin
        state_d = FS_HI;
        lo_d    = mem_rd_data;
      end
      FS_HI: if (mem_rd_ready) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == FS_IDLE) addr_q <= addr_d;
      if (state_q == FS_LO)   lo_q   <= lo_d;
    end
  end

  assign busy         = (state_q != FS_IDLE);
  assign mem_rd_valid = busy;
  assign mem_rd_addr  = (state_q == FS_HI) ? (addr_q + MADDR_W'(4)) : addr_q;
  assign done         = (state_q == FS_HI) && mem_rd_ready;

  assign done_shadow.limit = {mem_rd_data[19:16], lo_q[15:0]};
  assign done_shadow.base  = {mem_rd_data[31:24], mem_rd_data[7:0], lo_q[31:16]};
  assign attr_unused       = {mem_rd_data[23:20], mem_rd_data[15:8]};
endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc
  import seg_xlate_pkg::*;
#(
  parameter int OFF_W = 64
) (
  input  seg_shadow_t       shadow,
  input  logic [OFF_W-1:0]  offset,
  input  logic              mode64,
  output logic [OFF_W-1:0]  lin,
  output logic              fault
);
  logic [BASE_W-1:0] sum32;

  assign sum32 = shadow.base + offset[BASE_W-1:0];
  assign fault = !mode64 && (offset > OFF_W'(shadow.limit));
  assign lin   = mode64 ? offset : OFF_W'(sum32);
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEGS = 6,
  parameter int OFF_W    = 64,
  parameter int MADDR_W  = 32,
  localparam int IDX_W   = (NUM_SEGS > 1) ? $clog2(NUM_SEGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_wr_en,
  input  logic [IDX_W-1:0]   sel_wr_idx,
  input  logic [15:0]        sel_wr_val,
  input  logic [MADDR_W-1:0] gdt_base,
  input  logic [MADDR_W-1:0] ldt_base,
  input  logic               req_valid,
  input  logic [IDX_W-1:0]   req_seg,
  input  logic [OFF_W-1:0]   req_off,
  input  logic               req_mode64,
  output logic               busy,
  output logic               mem_rd_valid,
  output logic [MADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_ready,
  input  logic [31:0]        mem_rd_data,
  output logic               lin_valid,
  output logic [OFF_W-1:0]   lin_addr,
  output logic               gp_fault,
  output logic [1:0]         cpl
);
  logic               accept, cache_hit, fetch_start;
  logic [SEL_W-1:0]   rd_sel;
  logic               rd_valid;
  seg_shadow_t        rd_shadow, done_shadow, calc_shadow;
  logic               fetch_done;
  logic [MADDR_W-1:0] tbl_base, desc_addr;
  logic [1:0]         rpl_unused;

  logic [IDX_W-1:0]   pend_seg_q, pend_seg_d;
  logic [OFF_W-1:0]   pend_off_q, pend_off_d;
  logic               pend_m64_q, pend_m64_d;
  logic               kill_q, kill_d;

  logic [OFF_W-1:0]   calc_off, calc_lin;
  logic               calc_m64, calc_fault, result_now;
  logic               lin_valid_d, gp_fault_d;
  logic [OFF_W-1:0]   lin_addr_d;

  assign accept      = req_valid && !busy;
  assign cache_hit   = accept && rd_valid;
  assign fetch_start = accept && !rd_valid;

  seg_hidden_cache #(.NUM_SEGS(NUM_SEGS), .IDX_W(IDX_W)) u_cache (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (sel_wr_en),
    .wr_idx      (sel_wr_idx),
    .wr_sel      (sel_wr_val),
    .fill_en     (fetch_done && !kill_q),
    .fill_idx    (pend_seg_q),
    .fill_shadow (done_shadow),
    .rd_idx      (req_seg),
    .rd_sel      (rd_sel),
    .rd_valid    (rd_valid),
    .rd_shadow   (rd_shadow),
    .cs_rpl      (cpl)
  );

  assign tbl_base   = rd_sel[2] ? ldt_base : gdt_base;
  assign desc_addr  = tbl_base + MADDR_W'({rd_sel[15:3], 3'b000});
  assign rpl_unused = rd_sel[1:0];

  seg_desc_fetch #(.MADDR_W(MADDR_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (fetch_start),
    .start_addr   (desc_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .mem_rd_data  (mem_rd_data),
    .busy         (busy),
    .done         (fetch_done),
    .done_shadow  (done_shadow)
  );

  // Pending request context and the "selector reloaded mid-fetch" flag.
  always_comb begin
    pend_seg_d = pend_seg_q;
    pend_off_d = pend_off_q;
    pend_m64_d = pend_m64_q;
    kill_d     = kill_q;
    if (accept) begin
      pend_seg_d = req_seg;
      pend_off_d = req_off;
      pend_m64_d = req_mode64;
      kill_d     = sel_wr_en && (sel_wr_idx == req_seg);
    end else if (busy && sel_wr_en && (sel_wr_idx == pend_seg_q)) begin
      kill_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_seg_q <= '0;
      pend_off_q <= '0;
      pend_m64_q <= 1'b0;
      kill_q     <= 1'b0;
    end else begin
      if (accept) begin
        pend_seg_q <= pend_seg_d;
        pend_off_q <= pend_off_d;
        pend_m64_q <= pend_m64_d;
      end
      kill_q <= kill_d;
    end
  end

  assign calc_shadow = cache_hit ? rd_shadow  : done_shadow;
  assign calc_off    = cache_hit ? req_off    : pend_off_q;
  assign calc_m64    = cache_hit ? req_mode64 : pend_m64_q;

  seg_addr_calc #(.OFF_W(OFF_W)) u_calc (
    .shadow (calc_shadow),
    .offset (calc_off),
    .mode64 (calc_m64),
    .lin    (calc_lin),
    .fault  (calc_fault)
  );

  assign result_now  = cache_hit || fetch_done;
  assign lin_valid_d = result_now && !calc_fault;
  assign gp_fault_d  = result_now && calc_fault;
  assign lin_addr_d  = lin_valid_d ? calc_lin : lin_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lin_valid <= 1'b0;
      gp_fault  <= 1'b0;
      lin_addr  <= '0;
    end else begin
      lin_valid <= lin_valid_d;
      gp_fault  <= gp_fault_d;
      if (lin_valid_d) lin_addr <= lin_addr_d;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int IDX_W   = 3,
  parameter int MADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_mode64,
  input logic               busy,
  input logic               cache_hit,
  input logic               mem_rd_valid,
  input logic               mem_rd_ready,
  input logic [MADDR_W-1:0] mem_rd_addr,
  input logic               lin_valid,
  input logic               gp_fault,
  input logic               sel_wr_en,
  input logic [IDX_W-1:0]   sel_wr_idx,
  input logic [15:0]        sel_wr_val,
  input logic [1:0]         cpl
);
  // R9: never both outcomes at once
  a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(lin_valid && gp_fault));

  // R8: reads only while busy
  a_r8_read_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> busy);

  // R2: pending read holds its address
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R6: hit gives a result next cycle without a read
  a_r6_hit_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cache_hit) |=> (!mem_rd_valid && (lin_valid || gp_fault)));

  // R5: 64-bit hit never faults
  a_r5_no_fault_64: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && cache_hit && req_mode64) |=> lin_valid);

  // R10: privilege follows code-segment selector
  a_r10_cpl_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr_en && (sel_wr_idx == '0)) |=> (cpl == $past(sel_wr_val[1:0])));
endmodule

bind seg_xlate_unit seg_xlate_chk #(.IDX_W(IDX_W), .MADDR_W(MADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_mode64   (req_mode64),
  .busy         (busy),
  .cache_hit    (cache_hit),
  .mem_rd_valid (mem_rd_valid),
  .mem_rd_ready (mem_rd_ready),
  .mem_rd_addr  (mem_rd_addr),
  .lin_valid    (lin_valid),
  .gp_fault     (gp_fault),
  .sel_wr_en    (sel_wr_en),
  .sel_wr_idx   (sel_wr_idx),
  .sel_wr_val   (sel_wr_val),
  .cpl          (cpl)
);

// File: tb/tb_seg_xlate_unit.sv
module tb_seg_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEGS   = 6;
  localparam int IDX_W      = 3;
  localparam int OFF_W      = 64;
  localparam int MADDR_W    = 32;

  logic               clk, rst_n;
  logic               sel_wr_en;
  logic [IDX_W-1:0]   sel_wr_idx;
  logic [15:0]        sel_wr_val;
  logic [MADDR_W-1:0] gdt_base, ldt_base;
  logic               req_valid;
  logic [IDX_W-1:0]   req_seg;
  logic [OFF_W-1:0]   req_off;
  logic               req_mode64;
  logic               busy, mem_rd_valid, mem_rd_ready;
  logic [MADDR_W-1:0] mem_rd_addr;
  logic [31:0]        mem_rd_data;
  logic               lin_valid, gp_fault;
  logic [OFF_W-1:0]   lin_addr;
  logic [1:0]         cpl;

  seg_xlate_unit #(.NUM_SEGS(NUM_SEGS), .OFF_W(OFF_W), .MADDR_W(MADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx),
    .sel_wr_val(sel_wr_val), .gdt_base(gdt_base), .ldt_base(ldt_base),
    .req_valid(req_valid), .req_seg(req_seg), .req_off(req_off),
    .req_mode64(req_mode64), .busy(busy), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ready(mem_rd_ready),
    .mem_rd_data(mem_rd_data), .lin_valid(lin_valid), .lin_addr(lin_addr),
    .gp_fault(gp_fault), .cpl(cpl)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  // Memory contents: a fixed scramble of the word address.
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A51F07;
  endfunction

  function automatic logic [31:0] f_base(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[31:24], hi[7:0], lo[31:16]};
  endfunction

  function automatic logic [19:0] f_limit(input logic [31:0] lo, input logic [31:0] hi);
    return {hi[19:16], lo[15:0]};
  endfunction

  function automatic bit f_fault(input logic [63:0] off, input bit m64, input logic [19:0] lim);
    return !m64 && (off > {44'd0, lim});
  endfunction

  function automatic logic [63:0] f_lin(input logic [63:0] off, input bit m64, input logic [31:0] base);
    logic [31:0] s;
    s = base + off[31:0];
    return m64 ? off : {32'd0, s};
  endfunction

  // Bench model of the hidden copies
  bit          exp_vld  [NUM_SEGS];
  logic [15:0] exp_sel  [NUM_SEGS];
  logic [31:0] exp_base [NUM_SEGS];
  logic [19:0] exp_lim  [NUM_SEGS];

  // Memory responder
  int          rd_cnt = 0;
  int          rd_seq = 0;
  logic [31:0] rd_base = '0;
  string       rd_tag = "R2";

  always @(negedge clk) begin
    if (rst_n && mem_rd_valid) begin
      mem_rd_ready = ($urandom_range(0, 2) != 0);
      mem_rd_data  = mem_word(mem_rd_addr);
      if (mem_rd_ready) begin
        chk(mem_rd_addr == rd_base + 32'(4 * rd_seq), rd_tag, "read address",
            mem_rd_addr, rd_base + 32'(4 * rd_seq));
        rd_seq++;
        rd_cnt++;
      end
    end else begin
      mem_rd_ready = 1'b0;
      mem_rd_data  = '0;
    end
  end

  task automatic wr_sel(input int idx, input logic [15:0] v);
    @(negedge clk);
    sel_wr_en  = 1'b1;
    sel_wr_idx = IDX_W'(idx);
    sel_wr_val = v;
    @(negedge clk);
    sel_wr_en = 1'b0;
    exp_sel[idx] = v;
    exp_vld[idx] = 0;
    if (idx == 0) chk(cpl == v[1:0], "R10", "cpl after write", cpl, v[1:0]);
  endtask

  task automatic do_req(input int seg, input logic [63:0] off, input bit m64,
                        input string tag);
    logic [15:0] s;
    logic [31:0] a, lo, hi, base;
    logic [19:0] lim;
    bit          hit, ef;
    logic [63:0] el;
    int          c0, n;
    s   = exp_sel[seg];
    hit = exp_vld[seg];
    if (!hit) begin
      a    = (s[2] ? ldt_base : gdt_base) + {16'd0, s[15:3], 3'b000};
      lo   = mem_word(a);
      hi   = mem_word(a + 32'd4);
      base = f_base(lo, hi);
      lim  = f_limit(lo, hi);
      rd_base = a;
      rd_seq  = 0;
    end else begin
      base = exp_base[seg];
      lim  = exp_lim[seg];
    end
    ef = f_fault(off, m64, lim);
    el = f_lin(off, m64, base);
    c0 = rd_cnt;
    @(negedge clk);
    req_valid  = 1'b1;
    req_seg    = IDX_W'(seg);
    req_off    = off;
    req_mode64 = m64;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    if (!hit) chk(busy == 1'b1, "R8", "busy after miss accept", busy, 1);
    while (!(lin_valid || gp_fault) && n < 64) begin
      @(negedge clk);
      n++;
    end
    chk(gp_fault == ef, tag, "fault", gp_fault, ef);
    chk(lin_valid == !ef, tag, "lin_valid", lin_valid, !ef);
    if (!ef) chk(lin_addr == el, tag, "lin_addr", lin_addr, el);
    if (hit) begin
      chk(n == 1, "R6", "hit latency", n, 1);
      chk(rd_cnt == c0, "R6", "reads on hit", rd_cnt - c0, 0);
    end else begin
      chk(rd_cnt - c0 == 2, tag, "reads on miss", rd_cnt - c0, 2);
    end
    chk(busy == 1'b0, "R8", "busy at result", busy, 0);
    @(negedge clk);
    chk(!lin_valid && !gp_fault, "R9", "single pulse", {lin_valid, gp_fault}, 0);
    if (!hit) begin
      exp_vld[seg]  = 1;
      exp_base[seg] = base;
      exp_lim[seg]  = lim;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic [19:0] lim1;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel_wr_en = 0; sel_wr_idx = '0; sel_wr_val = '0;
    req_valid = 0; req_seg = '0; req_off = '0; req_mode64 = 0;
    gdt_base = 32'h0001_0000; ldt_base = 32'h0040_0000;
    mem_rd_ready = 0; mem_rd_data = '0;
    for (int i = 0; i < NUM_SEGS; i++) begin
      exp_vld[i] = 0; exp_sel[i] = '0; exp_base[i] = '0; exp_lim[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!busy && !lin_valid && !gp_fault && !mem_rd_valid, "R11", "reset outputs",
        {busy, lin_valid, gp_fault, mem_rd_valid}, 0);
    chk(cpl == 2'd0, "R11", "reset cpl", cpl, 0);
    rst_n = 1'b1;

    do_req(3, 64'h20, 0, "R11");              // nothing cached after reset

    wr_sel(0, 16'h0013);                      // index 2, global, RPL 3
    wr_sel(1, 16'h002C);                      // index 5, local, RPL 0
    rd_tag = "R1";
    do_req(1, 64'h0, 0, "R3");                // lin = base: field layout
    do_req(0, 64'h40, 0, "R1");
    rd_tag = "R2";

    lim1 = exp_lim[1];
    do_req(1, {44'd0, lim1}, 0, "R4");
    do_req(1, {44'd0, lim1} + 64'd1, 0, "R4");
    do_req(1, 64'hFFFF_0000_0000_0123, 0, "R4");
    do_req(1, 64'hFFFF_FFFF_FFFF_FFF0, 1, "R5");

    gdt_base = 32'h0077_7000;                 // stale base must not matter on hit
    do_req(0, 64'h7, 0, "R6");
    gdt_base = 32'h0001_0000;

    wr_sel(1, 16'h002C);                      // same value still invalidates
    do_req(1, 64'h5, 0, "R7");

    wr_sel(2, 16'hFFF8);
    do_req(2, 64'h8000_0000_1234_5678, 1, "R5");
    wr_sel(0, 16'h0008);

    for (int it = 0; it < 400; it++) begin
      int          seg;
      bit          m64;
      logic [63:0] off;
      seg = $urandom_range(0, NUM_SEGS - 1);
      if ($urandom_range(0, 3) == 0) begin
        wr_sel(seg, 16'($urandom));
      end else begin
        m64 = ($urandom_range(0, 2) == 0);
        if (m64) off = {$urandom, $urandom};
        else if ($urandom_range(0, 7) == 0) off = {$urandom, $urandom};
        else off = {43'd0, 21'($urandom)};
        do_req(seg, off, m64, m64 ? "R5" : "R4");
      end
    end

    summary();
    $finish;
  end
endmodule